// File: doc/BRIEF.md
# Row-Aware DRAM Request Scheduler

This block sits between several cores and an eight-bank DRAM model. Cores offer read requests, each tagged with its core, its warp, the bank, row and column it targets, and the number of instructions its warp has left. Pending requests wait in a sixteen-entry queue. Each clock, at most one waiting request is chosen and sent to the DRAM side. A second request to an address that is already waiting does not take a new slot. It joins the waiting entry, and every core that joined an entry is signalled when that access completes.

The scheduler remembers the open row of every bank. A request to the open row is a hit and finishes in one cycle. Any other request is a miss: it opens its row and keeps its bank unavailable for a fixed number of cycles. A two-bit policy input chooses the selection rule:

- strict arrival order;
- hits first, then oldest;
- hits first, then the warp that has been served least;
- hits first, then the warp with the most instructions left.

Top module: `dram_row_sched`

## Requirements
- R1: After reset the queue is empty, every bank has no open row, `req_ready` is 1, `iss_valid` is 0 and `done_mask` is 0.
- R2: With `policy` = 0 (arrival order), only the oldest waiting request may issue. If its bank is unavailable, nothing issues, even when a younger request targets a free bank.
- R3: With `policy` = 1, a request that hits its bank's open row is issued before any miss. Among requests of equal hit status, the oldest goes first.
- R4: With `policy` = 2, hits go first. Among requests of equal hit status, the request whose warp has been served the fewest times goes first, and a tie goes to the older request. A warp is identified by {core, warp}, and its served count rises by one, saturating, each time a request of its own issues.
- R5: With `policy` = 3, hits go first. Among requests of equal hit status, the request with the larger remaining-instruction count goes first, and a tie goes to the older request.
- R6: A request whose bank, row and column equal those of a waiting, not-currently-issuing entry is merged into that entry: no slot is used, bit `req_core` is set in the entry's requester mask, and one issue later serves all recorded requesters.
- R7: With sixteen entries waiting, `req_ready` is 0 for a request that cannot merge and 1 for one that can.
- R8: A hit is reported with `iss_hit` = 1, and `done_mask` carries its requester mask in the same cycle as `iss_valid`.
- R9: A miss (`iss_hit` = 0) makes its row the bank's open row. Its requester mask appears on `done_mask` exactly MISS_LAT cycles after its `iss_valid` cycle, and no request to that bank issues before then.
- R10: Every accepted, unmerged request issues exactly once, and nothing issues that was not requested.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| policy | input | 2 | 0 arrival order, 1 hit-then-oldest, 2 hit-then-least-served, 3 hit-then-most-remaining |
| req_valid | input | 1 | A request is offered |
| req_ready | output | 1 | The offered request is taken at this edge |
| req_core | input | 2 | Requesting core |
| req_warp | input | 3 | Warp within that core |
| req_bank | input | 3 | Target bank |
| req_row | input | 8 | Target row |
| req_col | input | 6 | Target column |
| req_rem | input | 8 | Instructions the warp has left |
| iss_valid | output | 1 | A request is issued this cycle |
| iss_bank | output | 3 | Bank of the issued request |
| iss_row | output | 8 | Row of the issued request |
| iss_col | output | 6 | Column of the issued request |
| iss_hit | output | 1 | The issued request hit the open row |
| done_mask | output | 4 | One bit per core whose access completes this cycle |

## Verification
A corrupted open-row record changes `iss_hit` and the issue order on the very next pick for that bank. A wrong busy countdown moves the miss's `done_mask` pulse away from its MISS_LAT slot, or lets a request issue early. A wrong served count or a wrong entry shift shows up as a reordered issue stream as soon as two candidates compete. A lost requester bit in a merged entry shows up as a missing `done_mask` bit when that entry completes. The bench holds requests behind a miss so that each policy faces a real choice, and compares every issue, in order, with a queue of expected results.

// File: rtl/drs_pkg.sv
// Shared field widths, policy encoding and queue entry layout for the
// row-aware DRAM scheduler. Assumes a power-of-two core and warp count.
package drs_pkg;
    localparam int NCORE  = 4;
    localparam int CORE_W = 2;
    localparam int WARP_W = 3;
    localparam int NBANK  = 8;
    localparam int BANK_W = 3;
    localparam int ROW_W  = 8;
    localparam int COL_W  = 6;
    localparam int REM_W  = 8;
    localparam int GW_W   = CORE_W + WARP_W;
    localparam int NGW    = 1 << GW_W;

    typedef enum logic [1:0] {
        POL_FCFS    = 2'd0,
        POL_FRFCFS  = 2'd1,
        POL_FRFAIR  = 2'd2,
        POL_REMINST = 2'd3
    } policy_e;

    typedef struct packed {
        logic [NCORE-1:0]  who;
        logic [GW_W-1:0]   gw;
        logic [BANK_W-1:0] bank;
        logic [ROW_W-1:0]  row;
        logic [COL_W-1:0]  col;
        logic [REM_W-1:0]  rem;
    } req_t;
endpackage

// File: rtl/drs_bank_track.sv
// Per-bank open-row record, miss countdown and completion signalling.
// Assumes at most one issue per cycle and MISS_LAT >= 1.
module drs_bank_track
    import drs_pkg::*;
#(
    parameter int MISS_LAT = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              iss_en,
    input  logic [BANK_W-1:0] iss_bank,
    input  logic [ROW_W-1:0]  iss_row,
    input  logic              iss_hit,
    input  logic [NCORE-1:0]  iss_who,
    output logic [ROW_W-1:0]  open_row [NBANK],
    output logic [NBANK-1:0]  row_vld,
    output logic [NBANK-1:0]  busy,
    output logic [NCORE-1:0]  done_mask
);
    localparam int CNT_W = $clog2(MISS_LAT + 1);

    logic [CNT_W-1:0] cnt [NBANK];
    logic [NCORE-1:0] pend [NBANK];
    logic [NBANK-1:0] fin;
    logic [NCORE-1:0] hit_q;

    for (genvar b = 0; b < NBANK; b++) begin : g_bank
        // Open row update, miss countdown and end-of-miss pulse for bank b.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                open_row[b] <= '0;
                row_vld[b]  <= 1'b0;
                cnt[b]      <= '0;
                pend[b]     <= '0;
                fin[b]      <= 1'b0;
            end else begin
                fin[b] <= 1'b0;
                if (iss_en && iss_bank == BANK_W'(b)) begin
                    open_row[b] <= iss_row;
                    row_vld[b]  <= 1'b1;
                    if (!iss_hit) begin
                        cnt[b]  <= CNT_W'(MISS_LAT);
                        pend[b] <= iss_who;
                    end
                end else if (cnt[b] != '0) begin
                    cnt[b] <= cnt[b] - 1'b1;
                    if (cnt[b] == CNT_W'(1)) fin[b] <= 1'b1;
                end
            end
        end

        assign busy[b] = (cnt[b] != '0);

        // R9: the picker never sends work to a bank that is still opening a row.
        a_r9_no_issue_busy: assert property (@(posedge clk) disable iff (!rst_n)
            (iss_en && iss_bank == BANK_W'(b)) |-> (cnt[b] == '0));
        // R9: a running miss counts down by one every cycle.
        a_r9_countdown: assert property (@(posedge clk) disable iff (!rst_n)
            (cnt[b] != '0) |=> (cnt[b] == $past(cnt[b]) - 1'b1));
    end

    // Hit completion is reported alongside the issue.
    always_ff @(posedge clk) begin
        if (!rst_n) hit_q <= '0;
        else        hit_q <= (iss_en && iss_hit) ? iss_who : '0;
    end

    // Merge hit completion with every bank's finishing miss.
    always_comb begin
        done_mask = hit_q;
        for (int b = 0; b < NBANK; b++) begin
            if (fin[b]) done_mask = done_mask | pend[b];
        end
    end
endmodule

// File: rtl/drs_warp_credit.sv
// Saturating served-request counter per global warp {core, warp};
// these counts measure warp progress for the fairness policy.
module drs_warp_credit
    import drs_pkg::*;
#(
    parameter int SRV_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             inc_en,
    input  logic [GW_W-1:0]  inc_gw,
    output logic [SRV_W-1:0] srv [NGW]
);
    for (genvar w = 0; w < NGW; w++) begin : g_warp
        // Count issues of warp w, holding at the maximum.
        always_ff @(posedge clk) begin
            if (!rst_n)                                       srv[w] <= '0;
            else if (inc_en && inc_gw == GW_W'(w) && srv[w] != '1) srv[w] <= srv[w] + 1'b1;
        end

        // R4: a saturated count never wraps back.
        a_r4_credit_sat: assert property (@(posedge clk) disable iff (!rst_n)
            (srv[w] == '1) |=> (srv[w] == '1));
    end
endmodule

// File: rtl/drs_pick.sv
// Combinational selection of the next request under the chosen policy.
// Assumes entry 0 is the oldest and entries at or above count are empty.
module drs_pick
    import drs_pkg::*;
#(
    parameter int DEPTH = 16,
    parameter int SRV_W = 8,
    localparam int IDX_W = $clog2(DEPTH),
    localparam int CNT_W = $clog2(DEPTH + 1)
) (
    input  policy_e           mode,
    input  req_t              q [DEPTH],
    input  logic [CNT_W-1:0]  count,
    input  logic [ROW_W-1:0]  open_row [NBANK],
    input  logic [NBANK-1:0]  row_vld,
    input  logic [NBANK-1:0]  busy,
    input  logic [SRV_W-1:0]  srv [NGW],
    output logic              sel_vld,
    output logic [IDX_W-1:0]  sel_idx,
    output logic              sel_hit
);
    // Scan from oldest to youngest; only a strictly better candidate replaces the best.
    always_comb begin
        req_t             e;
        logic             elig;
        logic             h;
        logic             better;
        logic [SRV_W-1:0] s;
        logic [SRV_W-1:0] b_srv;
        logic [REM_W-1:0] b_rem;
        sel_vld = 1'b0;
        sel_idx = '0;
        sel_hit = 1'b0;
        b_srv   = '0;
        b_rem   = '0;
        for (int i = 0; i < DEPTH; i++) begin
            e      = q[i];
            elig   = (i < int'(count)) && !busy[e.bank] && (mode != POL_FCFS || i == 0);
            h      = row_vld[e.bank] && (open_row[e.bank] == e.row);
            s      = srv[e.gw];
            better = 1'b0;
            if (elig) begin
                if (!sel_vld)              better = 1'b1;
                else if (h && !sel_hit)    better = 1'b1;
                else if (h == sel_hit) begin
                    case (mode)
                        POL_FRFAIR:  better = (s < b_srv);
                        POL_REMINST: better = (e.rem > b_rem);
                        default:     better = 1'b0;
                    endcase
                end
            end
            if (better) begin
                sel_vld = 1'b1;
                sel_idx = IDX_W'(i);
                sel_hit = h;
                b_srv   = s;
                b_rem   = e.rem;
            end
        end
    end
endmodule

// File: rtl/dram_row_sched.sv
// Top of the row-aware DRAM scheduler: an age-ordered request queue with
// address merging, a policy picker, bank state and warp progress counters.
// Assumes the DRAM side accepts one request per cycle without stalls.
module dram_row_sched
    import drs_pkg::*;
#(
    parameter int DEPTH    = 16,
    parameter int MISS_LAT = 8,
    parameter int SRV_W    = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [1:0]        policy,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic [CORE_W-1:0] req_core,
    input  logic [WARP_W-1:0] req_warp,
    input  logic [BANK_W-1:0] req_bank,
    input  logic [ROW_W-1:0]  req_row,
    input  logic [COL_W-1:0]  req_col,
    input  logic [REM_W-1:0]  req_rem,
    output logic              iss_valid,
    output logic [BANK_W-1:0] iss_bank,
    output logic [ROW_W-1:0]  iss_row,
    output logic [COL_W-1:0]  iss_col,
    output logic              iss_hit,
    output logic [NCORE-1:0]  done_mask
);
    localparam int IDX_W = $clog2(DEPTH);
    localparam int CNT_W = $clog2(DEPTH + 1);

    req_t             q [DEPTH];
    req_t             qm [DEPTH];
    req_t             qn [DEPTH];
    logic [CNT_W-1:0] count;
    logic [CNT_W-1:0] cnt_after;
    logic [DEPTH-1:0] match;
    logic             merge_hit;
    logic [IDX_W-1:0] merge_idx;
    logic             acc;
    req_t             incoming;
    policy_e          mode;

    logic              sel_vld;
    logic [IDX_W-1:0]  sel_idx;
    logic              sel_hit;
    logic [ROW_W-1:0]  open_row [NBANK];
    logic [NBANK-1:0]  row_vld;
    logic [NBANK-1:0]  busy;
    logic [SRV_W-1:0]  srv [NGW];
    req_t              sel_e;

    assign mode  = policy_e'(policy);
    assign sel_e = q[sel_idx];

    assign incoming = '{who: NCORE'(1) << req_core, gw: {req_core, req_warp},
                        bank: req_bank, row: req_row, col: req_col, rem: req_rem};

    // Find a waiting entry with the same address that is not leaving this cycle.
    always_comb begin
        merge_idx = '0;
        for (int i = DEPTH - 1; i >= 0; i--) begin
            match[i] = (i < int'(count)) && q[i].bank == req_bank && q[i].row == req_row
                       && q[i].col == req_col && !(sel_vld && sel_idx == IDX_W'(i));
            if (match[i]) merge_idx = IDX_W'(i);
        end
    end

    assign merge_hit = |match;
    assign req_ready = merge_hit || (count < CNT_W'(DEPTH));
    assign acc       = req_valid && req_ready;
    assign cnt_after = count - CNT_W'(sel_vld);

    // Next queue: merge the requester, close the gap of the issued entry, append.
    always_comb begin
        for (int i = 0; i < DEPTH; i++) begin
            qm[i] = q[i];
            if (acc && merge_hit && merge_idx == IDX_W'(i)) qm[i].who = q[i].who | incoming.who;
        end
        for (int i = 0; i < DEPTH - 1; i++) begin
            qn[i] = (sel_vld && IDX_W'(i) >= sel_idx) ? qm[i + 1] : qm[i];
        end
        qn[DEPTH - 1] = (sel_vld && sel_idx == IDX_W'(DEPTH - 1)) ? '0 : qm[DEPTH - 1];
        if (sel_vld && sel_idx != IDX_W'(DEPTH - 1)) qn[DEPTH - 1] = '0;
        for (int i = 0; i < DEPTH; i++) begin
            if (acc && !merge_hit && cnt_after == CNT_W'(i)) qn[i] = incoming;
        end
    end

    // Queue storage and occupancy.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            count <= '0;
            for (int i = 0; i < DEPTH; i++) q[i] <= '0;
        end else begin
            count <= cnt_after + CNT_W'(acc && !merge_hit);
            for (int i = 0; i < DEPTH; i++) q[i] <= qn[i];
        end
    end

    // Registered issue port toward the DRAM model.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            iss_valid <= 1'b0;
            iss_bank  <= '0;
            iss_row   <= '0;
            iss_col   <= '0;
            iss_hit   <= 1'b0;
        end else begin
            iss_valid <= sel_vld;
            iss_bank  <= sel_e.bank;
            iss_row   <= sel_e.row;
            iss_col   <= sel_e.col;
            iss_hit   <= sel_hit;
        end
    end

    drs_pick #(.DEPTH(DEPTH), .SRV_W(SRV_W)) u_pick (
        .mode(mode), .q(q), .count(count), .open_row(open_row), .row_vld(row_vld),
        .busy(busy), .srv(srv), .sel_vld(sel_vld), .sel_idx(sel_idx), .sel_hit(sel_hit)
    );

    drs_bank_track #(.MISS_LAT(MISS_LAT)) u_bank (
        .clk(clk), .rst_n(rst_n), .iss_en(sel_vld), .iss_bank(sel_e.bank),
        .iss_row(sel_e.row), .iss_hit(sel_hit), .iss_who(sel_e.who),
        .open_row(open_row), .row_vld(row_vld), .busy(busy), .done_mask(done_mask)
    );

    drs_warp_credit #(.SRV_W(SRV_W)) u_credit (
        .clk(clk), .rst_n(rst_n), .inc_en(sel_vld), .inc_gw(sel_e.gw), .srv(srv)
    );

    // R7: occupancy never exceeds the queue depth.
    a_r7_count_bound: assert property (@(posedge clk) disable iff (!rst_n)
        count <= CNT_W'(DEPTH));
    // R6: a merge with no issue leaves occupancy unchanged.
    a_r6_merge_keeps_count: assert property (@(posedge clk) disable iff (!rst_n)
        (acc && merge_hit && !sel_vld) |=> (count == $past(count)));
    // R8: an issued hit always completes for at least one requester in its cycle.
    a_r8_hit_done: assert property (@(posedge clk) disable iff (!rst_n)
        (iss_valid && iss_hit) |-> (done_mask != '0));
    // R10: an issue needs a waiting request in the cycle before.
    a_r10_issue_from_queue: assert property (@(posedge clk) disable iff (!rst_n)
        sel_vld |-> (count != '0));
endmodule

// File: tb/dram_row_sched_test.sv
// Scoreboard bench: scenarios push expected issues; a monitor compares them.
module dram_row_sched_test;
    localparam int LAT = 32;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [1:0] policy = 2'd1;
    logic       req_valid = 1'b0;
    logic       req_ready;
    logic [1:0] req_core = '0;
    logic [2:0] req_warp = '0;
    logic [2:0] req_bank = '0;
    logic [7:0] req_row = '0;
    logic [5:0] req_col = '0;
    logic [7:0] req_rem = '0;
    logic       iss_valid;
    logic [2:0] iss_bank;
    logic [7:0] iss_row;
    logic [5:0] iss_col;
    logic       iss_hit;
    logic [3:0] done_mask;

    typedef struct packed {
        logic [2:0] bank;
        logic [7:0] row;
        logic [5:0] col;
        logic       hit;
        logic [3:0] mask;
    } exp_t;

    exp_t  sb [$];
    string sb_tag [$];
    int    n_cmp = 0;
    int    n_bad = 0;
    bit    finished = 1'b0;
    exp_t  cur;
    string cur_tag;

    always #4 clk = ~clk;

    dram_row_sched #(.MISS_LAT(LAT)) uut (
        .clk(clk), .rst_n(rst_n), .policy(policy), .req_valid(req_valid), .req_ready(req_ready),
        .req_core(req_core), .req_warp(req_warp), .req_bank(req_bank), .req_row(req_row),
        .req_col(req_col), .req_rem(req_rem), .iss_valid(iss_valid), .iss_bank(iss_bank),
        .iss_row(iss_row), .iss_col(iss_col), .iss_hit(iss_hit), .done_mask(done_mask)
    );

    task automatic chk(input bit ok, input string what, input logic [31:0] act, input logic [31:0] exp);
        n_cmp++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", what, act, exp);
        end
    endtask

    task automatic expect_iss(input string tag, input logic [2:0] b, input logic [7:0] r,
                              input logic [5:0] c, input logic h, input logic [3:0] m);
        sb.push_back('{bank: b, row: r, col: c, hit: h, mask: m});
        sb_tag.push_back(tag);
    endtask

    // Drive at a falling edge; hold until taken at the next rising edge.
    task automatic send(input logic [1:0] core, input logic [2:0] warp, input logic [2:0] bank,
                        input logic [7:0] row, input logic [5:0] col, input logic [7:0] rem);
        req_valid = 1'b1; req_core = core; req_warp = warp;
        req_bank = bank; req_row = row; req_col = col; req_rem = rem;
        while (!req_ready) @(negedge clk);
        @(negedge clk);
        req_valid = 1'b0;
    endtask

    task automatic idle(input int n);
        req_valid = 1'b0;
        repeat (n) @(negedge clk);
    endtask

    task automatic do_reset(input logic [1:0] pol);
        policy = pol;
        rst_n = 1'b0;
        req_valid = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
    endtask

    task automatic drain(input string tag);
        int k = 0;
        while (sb.size() != 0 && k < 600) begin
            @(negedge clk);
            k++;
        end
        idle(3);
        chk(sb.size() == 0, {tag, " all expected issues seen"}, sb.size(), 0);
    endtask

    // Monitor: pop and compare each issue; hits must complete in the same cycle.
    always @(negedge clk) begin
        if (rst_n && iss_valid) begin
            if (sb.size() == 0) begin
                chk(1'b0, "R10 unexpected issue", {iss_bank, iss_row, iss_col}, 0);
            end else begin
                cur = sb.pop_front();
                cur_tag = sb_tag.pop_front();
                chk({iss_bank, iss_row, iss_col} == {cur.bank, cur.row, cur.col},
                    {cur_tag, " issue order bank/row/col"},
                    {iss_bank, iss_row, iss_col}, {cur.bank, cur.row, cur.col});
                chk(iss_hit == cur.hit, {cur_tag, " row hit flag"}, iss_hit, cur.hit);
                if (cur.hit)
                    chk(done_mask == cur.mask, {cur_tag, " R8 completion with hit"}, done_mask, cur.mask);
            end
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            n_cmp++;
            n_bad++;
            $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        int n;
        // R1: reset state.
        do_reset(2'd1);
        @(negedge clk);
        chk(req_ready == 1'b1, "R1 ready after reset", req_ready, 1);
        chk(iss_valid == 1'b0, "R1 no issue after reset", iss_valid, 0);
        chk(done_mask == 4'd0, "R1 no completion after reset", done_mask, 0);

        // R9: first access is a miss; completion LAT cycles after issue; then a hit.
        expect_iss("R9", 3'd5, 8'd3, 6'd1, 1'b0, 4'b0001);
        send(2'd0, 3'd0, 3'd5, 8'd3, 6'd1, 8'd0);
        while (!iss_valid) @(negedge clk);
        n = 0;
        do begin
            @(negedge clk);
            n++;
        end while (done_mask == 4'd0 && n < 100);
        chk(n == LAT, "R9 miss latency", n, LAT);
        chk(done_mask == 4'b0001, "R9 miss completion mask", done_mask, 4'b0001);
        expect_iss("R9 open row kept", 3'd5, 8'd3, 6'd2, 1'b1, 4'b0100);
        send(2'd2, 3'd0, 3'd5, 8'd3, 6'd2, 8'd0);
        drain("R9");

        // R3: hits before an older miss, oldest among hits.
        do_reset(2'd1);
        @(negedge clk);
        expect_iss("R3 blocker", 3'd2, 8'd5, 6'd0, 1'b0, 4'b0001);
        expect_iss("R3 first hit", 3'd2, 8'd5, 6'd2, 1'b1, 4'b0010);
        expect_iss("R3 second hit", 3'd2, 8'd5, 6'd3, 1'b1, 4'b0100);
        expect_iss("R3 older miss last", 3'd2, 8'd9, 6'd1, 1'b0, 4'b0001);
        send(2'd0, 3'd0, 3'd2, 8'd5, 6'd0, 8'd0);
        idle(2);
        send(2'd0, 3'd0, 3'd2, 8'd9, 6'd1, 8'd0);
        send(2'd1, 3'd0, 3'd2, 8'd5, 6'd2, 8'd0);
        send(2'd2, 3'd0, 3'd2, 8'd5, 6'd3, 8'd0);
        drain("R3");

        // R2: strict arrival order, including head-of-line blocking of a free bank.
        do_reset(2'd0);
        @(negedge clk);
        expect_iss("R2 blocker", 3'd2, 8'd5, 6'd0, 1'b0, 4'b0001);
        expect_iss("R2 oldest miss", 3'd2, 8'd9, 6'd1, 1'b0, 4'b0001);
        expect_iss("R2 second", 3'd2, 8'd5, 6'd2, 1'b0, 4'b0010);
        expect_iss("R2 third", 3'd2, 8'd5, 6'd3, 1'b1, 4'b0100);
        expect_iss("R2 blocked free bank", 3'd3, 8'd1, 6'd4, 1'b0, 4'b1000);
        send(2'd0, 3'd0, 3'd2, 8'd5, 6'd0, 8'd0);
        idle(2);
        send(2'd0, 3'd0, 3'd2, 8'd9, 6'd1, 8'd0);
        send(2'd1, 3'd0, 3'd2, 8'd5, 6'd2, 8'd0);
        send(2'd2, 3'd0, 3'd2, 8'd5, 6'd3, 8'd0);
        send(2'd3, 3'd0, 3'd3, 8'd1, 6'd4, 8'd0);
        drain("R2");

        // R4: least-served warp wins among hits.
        do_reset(2'd2);
        @(negedge clk);
        expect_iss("R4 blocker", 3'd4, 8'd2, 6'd0, 1'b0, 4'b0001);
        expect_iss("R4 least served", 3'd4, 8'd2, 6'd2, 1'b1, 4'b0010);
        expect_iss("R4 served warp", 3'd4, 8'd2, 6'd1, 1'b1, 4'b0001);
        expect_iss("R4 miss last", 3'd4, 8'd7, 6'd3, 1'b0, 4'b0100);
        send(2'd0, 3'd1, 3'd4, 8'd2, 6'd0, 8'd0);
        idle(2);
        send(2'd2, 3'd0, 3'd4, 8'd7, 6'd3, 8'd0);
        send(2'd0, 3'd1, 3'd4, 8'd2, 6'd1, 8'd0);
        send(2'd1, 3'd0, 3'd4, 8'd2, 6'd2, 8'd0);
        drain("R4");

        // R5: most remaining instructions wins among hits; hit still beats a larger miss.
        do_reset(2'd3);
        @(negedge clk);
        expect_iss("R5 blocker", 3'd6, 8'd3, 6'd0, 1'b0, 4'b0001);
        expect_iss("R5 most remaining hit", 3'd6, 8'd3, 6'd2, 1'b1, 4'b0010);
        expect_iss("R5 fewer remaining hit", 3'd6, 8'd3, 6'd1, 1'b1, 4'b0001);
        expect_iss("R5 miss last", 3'd6, 8'd8, 6'd9, 1'b0, 4'b0001);
        send(2'd0, 3'd0, 3'd6, 8'd3, 6'd0, 8'd0);
        idle(2);
        send(2'd0, 3'd4, 3'd6, 8'd8, 6'd9, 8'd200);
        send(2'd0, 3'd2, 3'd6, 8'd3, 6'd1, 8'd10);
        send(2'd1, 3'd3, 3'd6, 8'd3, 6'd2, 8'd50);
        drain("R5");

        // R7 and R6: fill the queue, refuse a new address, accept a mergeable one.
        do_reset(2'd0);
        @(negedge clk);
        expect_iss("R7 blocker", 3'd0, 8'd0, 6'd0, 1'b0, 4'b0001);
        for (int k = 1; k <= 16; k++)
            expect_iss(k == 5 ? "R6 merged entry" : "R7 queued", 3'd0, 8'd0, 6'(k), 1'b1,
                       k == 5 ? 4'b0011 : 4'b0001);
        send(2'd0, 3'd0, 3'd0, 8'd0, 6'd0, 8'd0);
        idle(2);
        for (int k = 1; k <= 16; k++) send(2'd0, 3'd0, 3'd0, 8'd0, 6'(k), 8'd0);
        req_valid = 1'b1; req_core = 2'd0; req_bank = 3'd0; req_row = 8'd0; req_col = 6'd40;
        #1;
        chk(req_ready == 1'b0, "R7 full refuses new address", req_ready, 0);
        req_core = 2'd1; req_col = 6'd5;
        #1;
        chk(req_ready == 1'b1, "R7 full still merges", req_ready, 1);
        @(negedge clk);
        idle(1);
        drain("R6");

        finished = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule